// File: doc/BRIEF.md
# Encoder Position Delta Scheduler

This block sits in front of a quadrature pulse emulator. Software writes an absolute position once per update period. A one-cycle sync pulse marks the start of each period. After a programmable number of clock cycles the block samples the written position and the index settings. It subtracts its own stored position from the sampled one to get a signed edge delta. It then adopts the sampled value as its new stored position.

If the size of the delta is above a configurable ceiling, the move is treated as a runaway jump. The delta is then cut to its signed remainder modulo 4, so only the quadrature phase is brought back in line. The result is held back until the following sync. At that sync it is issued as an edge count and a direction, together with a one-cycle start strobe and the index settings captured with it. The phase state, which is the two low bits of the stored position, is available at all times.

Top module: `quad_delta_sched`

## Requirements
- R1: After reset, the stored position is 0. `phase` is 0, `count` is 0, `dir` is 1, `start` is 0, and both index outputs are 0.
- R2: Let the rising edge that samples `sync` high be edge 0. `pos_in`, `max_delta`, `idx_delay_in` and `idx_hold_in` are then captured at edge D+1, where D is the value of `latch_delay` sampled with that sync.
- R3: If a new sync arrives before the capture for the previous sync has taken place, the delay restarts from the new sync. The earlier capture never happens, and the stored position is left untouched until the restarted delay expires.
- R4: At capture, the delta is `pos_in` minus the stored position, computed in 32-bit two's-complement with wrap. When the size of the delta is no more than the limit, `count` is that size. In every case the stored position becomes `pos_in`.
- R5: `phase` always equals bits [1:0] of the stored position. It changes in the cycle after the capture edge.
- R6: `dir` is 1 when the issued delta (after any reduction) is zero or positive, and 0 when it is negative.
- R7: When the size of the delta exceeds the limit, the delta is replaced by its remainder modulo 4, which carries the sign of the delta. A jump from 0 to 0x1001 gives `count`=1 and `dir`=1. A jump of -0x1001 gives `count`=1 and `dir`=0.
- R8: A `max_delta` of 0 selects the default limit of 250. Any other value is used as given.
- R9: At the first sync after a capture, the pending result is issued. `start` is high for exactly the one cycle after that sync edge. `count`, `dir`, `idx_delay` and `idx_hold` update in that same cycle and then hold until the next issue.
- R10: A sync with no capture pending since the last issue raises no `start` and leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | One-cycle period marker |
| latch_delay | input | DLY_W | Cycles from sync to capture (capture at edge D+1) |
| pos_in | input | POS_W | Written absolute position, signed |
| max_delta | input | LIM_W | Delta ceiling; 0 selects 250 |
| idx_delay_in | input | IDX_W | Index edge delay setting |
| idx_hold_in | input | 1 | Index hold-high setting |
| count | output | POS_W | Edge count issued at sync |
| dir | output | 1 | 1 = non-negative move, 0 = negative |
| start | output | 1 | One-cycle issue strobe |
| idx_delay | output | IDX_W | Index delay captured with the issued count |
| idx_hold | output | 1 | Index hold flag captured with the issued count |
| phase | output | 2 | Low two bits of the stored position |

## Verification
A capture is due at edge D+1 after the sync edge, and the new `phase` is visible from the cycle that follows it. An issued result is visible in the cycle after the sync edge that releases it, and `start` falls one cycle later. The bench drives inputs on the falling edge. Its behavioural model advances once per rising edge and counts edges down to the capture. Every output is compared on the next falling edge, so each expectation is checked in exactly the cycle in which the design's registers are due to change.

// File: rtl/qds_pkg.sv
package qds_pkg;
    localparam int unsigned DEF_LIMIT = 250;

    function automatic logic [1:0] low_phase(input logic [31:0] p);
        return p[1:0];
    endfunction
endpackage

// File: rtl/qds_timer.sv
module qds_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [DLY_W-1:0] delay,
    output logic             fire
);
    typedef struct packed {
        logic             armed;
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign fire = st_q.armed && (st_q.cnt == '0) && !sync;

    always_comb begin
        st_d = st_q;
        if (sync) begin
            st_d.armed = 1'b1;
            st_d.cnt   = delay;
        end else if (st_q.armed) begin
            if (st_q.cnt == '0) st_d.armed = 1'b0;
            else                st_d.cnt   = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qds_delta.sv
module qds_delta #(
    parameter int POS_W     = 32,
    parameter int LIM_W     = 16,
    parameter int DEF_LIMIT = 250
) (
    input  logic [POS_W-1:0] target,
    input  logic [POS_W-1:0] current,
    input  logic [LIM_W-1:0] limit_in,
    output logic [POS_W-1:0] mag,
    output logic             dir
);
    localparam int EXT_W = (POS_W > LIM_W) ? POS_W : LIM_W;

    logic [POS_W-1:0] diff;
    logic [POS_W-1:0] full_mag;
    logic [EXT_W-1:0] lim_ext;
    logic [EXT_W-1:0] mag_ext;
    logic             neg;
    logic             over;

    always_comb begin
        diff     = target - current;
        neg      = diff[POS_W-1];
        full_mag = neg ? (~diff + 1'b1) : diff;
        lim_ext  = (limit_in == '0) ? EXT_W'(DEF_LIMIT) : EXT_W'(limit_in);
        mag_ext  = EXT_W'(full_mag);
        over     = mag_ext > lim_ext;
        if (over) mag = {{(POS_W-2){1'b0}}, full_mag[1:0]};
        else      mag = full_mag;
        dir = !neg || (mag == '0);
    end
endmodule

// File: rtl/quad_delta_sched.sv
module quad_delta_sched #(
    parameter int POS_W = 32,
    parameter int DLY_W = 16,
    parameter int LIM_W = 16,
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [DLY_W-1:0] latch_delay,
    input  logic [POS_W-1:0] pos_in,
    input  logic [LIM_W-1:0] max_delta,
    input  logic [IDX_W-1:0] idx_delay_in,
    input  logic             idx_hold_in,
    output logic [POS_W-1:0] count,
    output logic             dir,
    output logic             start,
    output logic [IDX_W-1:0] idx_delay,
    output logic             idx_hold,
    output logic [1:0]       phase
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             pend;
        logic [POS_W-1:0] pcnt;
        logic             pdir;
        logic [IDX_W-1:0] pidx_dly;
        logic             pidx_hold;
        logic [POS_W-1:0] cnt;
        logic             dir;
        logic             start;
        logic [IDX_W-1:0] idx_dly;
        logic             idx_hold;
    } sched_t;

    localparam sched_t RESET_ST = '{
        pos: '0, pend: 1'b0, pcnt: '0, pdir: 1'b1, pidx_dly: '0,
        pidx_hold: 1'b0, cnt: '0, dir: 1'b1, start: 1'b0,
        idx_dly: '0, idx_hold: 1'b0
    };

    sched_t           st_d, st_q;
    logic             fire;
    logic [POS_W-1:0] step_mag;
    logic             step_dir;

    qds_timer #(.DLY_W(DLY_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (sync),
        .delay (latch_delay),
        .fire  (fire)
    );

    qds_delta #(
        .POS_W     (POS_W),
        .LIM_W     (LIM_W),
        .DEF_LIMIT (qds_pkg::DEF_LIMIT)
    ) u_delta (
        .target   (pos_in),
        .current  (st_q.pos),
        .limit_in (max_delta),
        .mag      (step_mag),
        .dir      (step_dir)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (fire) begin
            st_d.pos       = pos_in;
            st_d.pend      = 1'b1;
            st_d.pcnt      = step_mag;
            st_d.pdir      = step_dir;
            st_d.pidx_dly  = idx_delay_in;
            st_d.pidx_hold = idx_hold_in;
        end
        if (sync && st_q.pend) begin
            st_d.pend     = 1'b0;
            st_d.cnt      = st_q.pcnt;
            st_d.dir      = st_q.pdir;
            st_d.idx_dly  = st_q.pidx_dly;
            st_d.idx_hold = st_q.pidx_hold;
            st_d.start    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign dir       = st_q.dir;
    assign start     = st_q.start;
    assign idx_delay = st_q.idx_dly;
    assign idx_hold  = st_q.idx_hold;
    assign phase     = st_q.pos[1:0];
endmodule

// File: rtl/qds_checker.sv
module qds_checker #(
    parameter int POS_W = 32,
    parameter int LIM_W = 16,
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync,
    input logic [POS_W-1:0] count,
    input logic             dir,
    input logic             start,
    input logic [IDX_W-1:0] idx_delay,
    input logic             idx_hold
);
    a_r9_start_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(sync));

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    a_r9_hold_between_issues: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> ($stable(count) && $stable(dir) && $stable(idx_delay) && $stable(idx_hold)));

    a_r6_negative_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dir) |-> (count != '0));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((count >> LIM_W) == '0));
endmodule

bind quad_delta_sched qds_checker #(
    .POS_W (POS_W),
    .LIM_W (LIM_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (sync),
    .count     (count),
    .dir       (dir),
    .start     (start),
    .idx_delay (idx_delay),
    .idx_hold  (idx_hold)
);

// File: tb/quad_delta_sched_test.sv
module quad_delta_sched_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic [15:0] latch_delay = 16'd3;
    logic [31:0] pos_in = '0;
    logic [15:0] max_delta = '0;
    logic [15:0] idx_delay_in = '0;
    logic        idx_hold_in = 1'b0;
    logic [31:0] count;
    logic        dir, start, idx_hold;
    logic [15:0] idx_delay;
    logic [1:0]  phase;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit          m_armed = 0;
    int          m_wait = 0;
    bit          m_pend = 0;
    longint      m_pcnt = 0;
    bit          m_pdir = 1;
    int          m_pidd = 0;
    bit          m_pidh = 0;
    int          m_pos = 0;
    longint      m_cnt = 0;
    bit          m_dir = 1;
    bit          m_start = 0;
    int          m_idd = 0;
    bit          m_idh = 0;

    always #(PERIOD/2) clk = ~clk;

    quad_delta_sched uut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .latch_delay(latch_delay),
        .pos_in(pos_in), .max_delta(max_delta), .idx_delay_in(idx_delay_in),
        .idx_hold_in(idx_hold_in), .count(count), .dir(dir), .start(start),
        .idx_delay(idx_delay), .idx_hold(idx_hold), .phase(phase)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit     fire_now;
        bit     sync_now;
        int     di;
        longint mag, lim, r;
        sync_now = sync;
        fire_now = 0;
        if (sync_now) begin
            m_armed = 1;
            m_wait  = int'(latch_delay) + 1;
        end else if (m_armed) begin
            m_wait--;
            if (m_wait == 0) begin
                fire_now = 1;
                m_armed  = 0;
            end
        end
        m_start = 0;
        if (sync_now && m_pend) begin
            m_pend = 0; m_cnt = m_pcnt; m_dir = m_pdir;
            m_idd = m_pidd; m_idh = m_pidh; m_start = 1;
        end
        if (fire_now) begin
            di  = int'(pos_in) - m_pos;
            mag = (di < 0) ? -longint'(di) : longint'(di);
            lim = (max_delta == 0) ? 250 : longint'(max_delta);
            if (mag > lim) begin
                r = longint'(di) % 4;
                m_pcnt = (r < 0) ? -r : r;
                m_pdir = (r >= 0);
            end else begin
                m_pcnt = mag;
                m_pdir = (di >= 0);
            end
            m_pidd = int'(idx_delay_in);
            m_pidh = idx_hold_in;
            m_pos  = int'(pos_in);
            m_pend = 1;
        end
    endtask

    task automatic compare_all();
        chk("R9 start", longint'(start), longint'(m_start));
        chk("R4 count", longint'(count), m_cnt);
        chk("R6 dir", longint'(dir), longint'(m_dir));
        chk("R5 phase", longint'(phase), longint'(m_pos & 3));
        chk("R9 idx_delay", longint'(idx_delay), longint'(m_idd));
        chk("R9 idx_hold", longint'(idx_hold), longint'(m_idh));
    endtask

    // one clock: inputs already set at a falling edge
    task automatic step(input bit s);
        sync = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    // full period: sync, set inputs, wait beyond the capture, then issue
    task automatic period(input logic [31:0] p, input logic [15:0] lim);
        step(1'b1);
        pos_in = p; max_delta = lim;
        idle(int'(latch_delay) + 2);
        step(1'b1);
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", longint'(count), 0);
        chk("R1 dir", longint'(dir), 1);
        chk("R1 start", longint'(start), 0);
        chk("R1 phase", longint'(phase), 0);
        chk("R1 idx_delay", longint'(idx_delay), 0);

        // R2 capture timing: phase changes only after edge D+1
        step(1'b1);
        pos_in = 32'd6; idx_delay_in = 16'd7; idx_hold_in = 1'b1;
        idle(int'(latch_delay));
        chk("R2 before capture", longint'(phase), 0);
        step(1'b0);
        chk("R2 after capture", longint'(phase), 2);
        idle(2);
        step(1'b1);
        chk("R9 start", longint'(start), 1);
        chk("R4 count 6", longint'(count), 6);
        chk("R9 idx_delay", longint'(idx_delay), 7);
        step(1'b0);
        chk("R9 strobe ends", longint'(start), 0);

        // R6 negative move
        period(32'd2, 16'd0);
        chk("R6 dir neg", longint'(dir), 0);
        chk("R4 count 4", longint'(count), 4);

        // R7 jumps beyond the limit
        period(32'd2 + 32'h1001, 16'd0);
        chk("R7 count +1", longint'(count), 1);
        chk("R7 dir +", longint'(dir), 1);
        period(32'd2, 16'd0);
        chk("R7 count -1", longint'(count), 1);
        chk("R7 dir -", longint'(dir), 0);

        // R8 default limit 250 versus explicit limit
        period(32'd252, 16'd0);
        chk("R8 count 250", longint'(count), 250);
        period(32'd503, 16'd0);
        chk("R8 count 251 reduced", longint'(count), 3);
        period(32'd803, 16'd400);
        chk("R8 explicit limit", longint'(count), 300);
        period(32'hFFFF_FFF0, 16'd0);
        chk("R7 wrap reduced", longint'(count), 3);
        chk("R7 wrap dir", longint'(dir), 0);

        // R3 restart: early sync skips the first capture, R10 no strobe
        latch_delay = 16'd6;
        step(1'b1);
        pos_in = 32'd100; max_delta = 16'd0;
        idle(2);
        step(1'b1);
        chk("R10 no strobe", longint'(start), 0);
        chk("R10 count held", longint'(count), 3);
        pos_in = 32'hFFFF_FFF3;
        idle(6);
        chk("R3 skipped capture", longint'(phase), 0);
        idle(2);
        chk("R3 late capture", longint'(phase), 3);
        step(1'b1);
        chk("R3 count", longint'(count), 3);
        chk("R3 dir", longint'(dir), 1);

        // zero delay and a zero move
        latch_delay = 16'd0;
        period(32'hFFFF_FFF3, 16'd5);
        chk("R6 zero move dir", longint'(dir), 1);
        chk("R4 zero move", longint'(count), 0);
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule